// File: doc/BRIEF.md
# Stochastic Bitstream Encoder and Arithmetic Unit

This block turns unsigned 16-bit probability words into Bernoulli bitstreams and runs stochastic arithmetic on them. Three pseudo-random lanes each hold a 16-bit maximal-length Fibonacci shift register. Two lanes encode the operands A and B. The third lane encodes the constant one half and drives the select of a 2:1 multiplexer. Each cycle of a run, a lane emits a 1 when its register state is strictly below the lane's threshold. The block forms the product stream (A AND B) and the scaled-sum stream (a multiplexer between A and B). It counts the ones of A, of the product and of the sum over a run of programmable length.

A run begins with a one-cycle `start`. On that edge the block latches the operand words and the length, and loads every lane from its seed. A zero seed is replaced by a fixed nonzero default, so the output is bit-exact and can be reproduced. On each following clock edge one bit is produced, until the configured number of bits is complete. `done` then pulses together with the last bit. The counters hold their totals until the next `start`.

Top module: `sc_stream_engine`

## Requirements
- R1: While a run is active, lane A's bit is 1 exactly when lane A's register state is strictly less than the latched `val_a`, and the same rule holds for lane B with `val_b`. A value of 0 gives a stream with no ones.
- R2: Each lane steps as a left-shifting Fibonacci register. The new bit 0 is the XOR of state bits 15, 13, 12 and 10 (polynomial x^16+x^14+x^13+x^11+1). The sequence visits all 65,535 nonzero states, so a 65,535-bit run with threshold 0xFFFF yields 65,534 ones.
- R3: On `start` each lane loads its seed. A zero seed loads that lane's default instead: 0xACE1 for A, 0x3C5B for B, 0x91E7 for the select lane.
- R4: If the effective seed of B equals the effective seed of A, lane B loads that seed plus one instead (0x0001 when it is 0xFFFF). The operand streams are therefore never identical.
- R5: `prod_bit` is the AND of `bit_a` and `bit_b`.
- R6: `bit_sel` is 1 when the select lane state is below 0x8000. `sum_bit` equals `bit_a` when `bit_sel` is 1, and equals `bit_b` otherwise.
- R7: `cnt_a`, `cnt_prod` and `cnt_sum` are cleared on `start`. Each one then counts the ones of its stream over the bits produced so far.
- R8: A `len_in` of 0 selects a run of 1024 bits. Any other value gives exactly that many bits, each marked by `stream_valid`.
- R9: `done` is high for exactly one cycle per run: the cycle in which the last bit is shown. In that cycle `busy` is already low.
- R10: A `start` during a run abandons that run and begins a new run at once, with fresh seeds, operands, length and counters.
- R11: After reset, `busy`, `stream_valid`, `done`, all stream bits and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (latches operands, length and seeds) |
| len_in | input | LEN_W | Run length in bits, 0 selects 1024 |
| val_a | input | 16 | Probability word of operand A |
| val_b | input | 16 | Probability word of operand B |
| seed_a | input | 16 | Seed of lane A |
| seed_b | input | 16 | Seed of lane B |
| seed_s | input | 16 | Seed of the select lane |
| busy | output | 1 | A run is in progress |
| stream_valid | output | 1 | The stream bits of this cycle belong to the run |
| bit_a | output | 1 | Encoded bit of A |
| bit_b | output | 1 | Encoded bit of B |
| bit_sel | output | 1 | Select stream bit (probability one half) |
| prod_bit | output | 1 | Product stream bit |
| sum_bit | output | 1 | Scaled-sum stream bit |
| cnt_a | output | LEN_W | Ones counted in stream A |
| cnt_prod | output | LEN_W | Ones counted in the product stream |
| cnt_sum | output | LEN_W | Ones counted in the sum stream |
| done | output | 1 | One-cycle pulse with the last bit of a run |

## Verification
A full 65,535-bit run with threshold 0xFFFF must yield exactly 65,534 ones. Wrong feedback taps or a wrong comparison direction would shorten the cycle or shift the count. A zero seed must give the same totals as the default seed. A design that loads zero as given would lock its lane at zero and count no ones. Equal A and B seeds must give the same product total as an explicit seed-plus-one run. Without the fix, the product would collapse to stream A itself. Runs of length 1, the default length, and a restart in the middle of a run expose off-by-one termination, repeated `done` pulses and counters that are not cleared.

// File: rtl/sc_stream_pkg.sv
package sc_stream_pkg;

    localparam int RNG_W     = 16;
    localparam int NUM_LANES = 3;

    typedef logic [RNG_W-1:0] rng_t;

    localparam rng_t HALF_THRESH = 16'h8000;

    // Lane indices
    localparam int LANE_A   = 0;
    localparam int LANE_B   = 1;
    localparam int LANE_SEL = 2;

    typedef struct packed {
        logic a;
        logic b;
        logic sel;
        logic prod;
        logic sum;
    } sc_bits_t;

    // Fibonacci step, taps x^16 + x^14 + x^13 + x^11 + 1
    function automatic rng_t rng_advance(rng_t s);
        return {s[RNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic rng_t seed_or_default(rng_t s, rng_t d);
        return (s == '0) ? d : s;
    endfunction

    // Nonzero neighbour of a nonzero seed
    function automatic rng_t seed_bump(rng_t s);
        return (s == '1) ? rng_t'(1) : s + rng_t'(1);
    endfunction

    function automatic logic encode_bit(rng_t state, rng_t thresh);
        return state < thresh;
    endfunction

endpackage

// File: rtl/sc_rng_lane.sv
module sc_rng_lane
    import sc_stream_pkg::*;
#(
    parameter rng_t RESET_SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  rng_t seed,
    input  logic step,
    input  rng_t thresh,
    output rng_t state,
    output logic bit_o
);
    rng_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_SEED;
        end else if (load) begin
            state_q <= seed;
        end else if (step) begin
            state_q <= rng_advance(state_q);
        end
    end

    assign state = state_q;
    assign bit_o = encode_bit(state_q, thresh);
endmodule

// File: rtl/sc_popcount.sv
module sc_popcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc_en,
    input  logic             bit_i,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else if (inc_en && bit_i) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count = count_q;
endmodule

// File: rtl/sc_run_ctrl.sv
module sc_run_ctrl #(
    parameter int LEN_W       = 16,
    parameter int DEFAULT_LEN = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len_in,
    output logic             busy,
    output logic             step,
    output logic             stream_valid,
    output logic             done
);
    localparam logic [LEN_W-1:0] DEF_LEN = LEN_W'(DEFAULT_LEN);

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx_q;
    logic             busy_q;
    logic             valid_q;
    logic             done_q;

    assign step = busy_q & ~start;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            len_q   <= '0;
            idx_q   <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            len_q   <= (len_in == '0) ? DEF_LEN : len_in;
            idx_q   <= '0;
        end else if (busy_q) begin
            valid_q <= 1'b1;
            idx_q   <= idx_q + LEN_W'(1);
            if (idx_q == len_q - LEN_W'(1)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                done_q <= 1'b0;
            end
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end
    end

    assign busy         = busy_q;
    assign stream_valid = valid_q;
    assign done         = done_q;
endmodule

// File: rtl/sc_stream_engine.sv
module sc_stream_engine
    import sc_stream_pkg::*;
#(
    parameter int   LEN_W       = 16,
    parameter int   DEFAULT_LEN = 1024,
    parameter rng_t DEF_SEED_A  = 16'hACE1,
    parameter rng_t DEF_SEED_B  = 16'h3C5B,
    parameter rng_t DEF_SEED_S  = 16'h91E7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len_in,
    input  logic [15:0]      val_a,
    input  logic [15:0]      val_b,
    input  logic [15:0]      seed_a,
    input  logic [15:0]      seed_b,
    input  logic [15:0]      seed_s,
    output logic             busy,
    output logic             stream_valid,
    output logic             bit_a,
    output logic             bit_b,
    output logic             bit_sel,
    output logic             prod_bit,
    output logic             sum_bit,
    output logic [LEN_W-1:0] cnt_a,
    output logic [LEN_W-1:0] cnt_prod,
    output logic [LEN_W-1:0] cnt_sum,
    output logic             done
);
    localparam rng_t LANE_DEF [NUM_LANES] = '{DEF_SEED_A, DEF_SEED_B, DEF_SEED_S};

    logic step;
    rng_t val_a_q, val_b_q;
    rng_t eff_a, eff_b_raw, eff_b, eff_s;
    rng_t lane_seed  [NUM_LANES];
    rng_t lane_thr   [NUM_LANES];
    rng_t lane_state [NUM_LANES];
    logic lane_bit   [NUM_LANES];
    rng_t rng_a_state, rng_b_state, rng_s_state;
    sc_bits_t nxt_bits, out_q;
    logic cnt_src [NUM_LANES];
    logic [LEN_W-1:0] cnt_val [NUM_LANES];

    // Run sequencing
    sc_run_ctrl #(
        .LEN_W      (LEN_W),
        .DEFAULT_LEN(DEFAULT_LEN)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .len_in      (len_in),
        .busy        (busy),
        .step        (step),
        .stream_valid(stream_valid),
        .done        (done)
    );

    // Operand capture
    always_ff @(posedge clk) begin
        if (rst) begin
            val_a_q <= '0;
            val_b_q <= '0;
        end else if (start) begin
            val_a_q <= val_a;
            val_b_q <= val_b;
        end
    end

    // Seed conditioning: zero substitution and A/B decorrelation
    always_comb begin
        eff_a     = seed_or_default(seed_a, DEF_SEED_A);
        eff_b_raw = seed_or_default(seed_b, DEF_SEED_B);
        eff_b     = (eff_b_raw == eff_a) ? seed_bump(eff_a) : eff_b_raw;
        eff_s     = seed_or_default(seed_s, DEF_SEED_S);
    end

    assign lane_seed[LANE_A]   = eff_a;
    assign lane_seed[LANE_B]   = eff_b;
    assign lane_seed[LANE_SEL] = eff_s;
    assign lane_thr[LANE_A]    = val_a_q;
    assign lane_thr[LANE_B]    = val_b_q;
    assign lane_thr[LANE_SEL]  = HALF_THRESH;

    // Random lanes
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        sc_rng_lane #(
            .RESET_SEED(LANE_DEF[g])
        ) u_lane (
            .clk   (clk),
            .rst   (rst),
            .load  (start),
            .seed  (lane_seed[g]),
            .step  (step),
            .thresh(lane_thr[g]),
            .state (lane_state[g]),
            .bit_o (lane_bit[g])
        );
    end

    assign rng_a_state = lane_state[LANE_A];
    assign rng_b_state = lane_state[LANE_B];
    assign rng_s_state = lane_state[LANE_SEL];

    // Stochastic arithmetic
    always_comb begin
        nxt_bits.a    = lane_bit[LANE_A];
        nxt_bits.b    = lane_bit[LANE_B];
        nxt_bits.sel  = lane_bit[LANE_SEL];
        nxt_bits.prod = nxt_bits.a & nxt_bits.b;
        nxt_bits.sum  = nxt_bits.sel ? nxt_bits.a : nxt_bits.b;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            out_q <= '0;
        end else if (step) begin
            out_q <= nxt_bits;
        end
    end

    assign bit_a    = out_q.a;
    assign bit_b    = out_q.b;
    assign bit_sel  = out_q.sel;
    assign prod_bit = out_q.prod;
    assign sum_bit  = out_q.sum;

    // Integration
    assign cnt_src[0] = nxt_bits.a;
    assign cnt_src[1] = nxt_bits.prod;
    assign cnt_src[2] = nxt_bits.sum;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_count
        sc_popcount #(
            .CNT_W(LEN_W)
        ) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clear (start),
            .inc_en(step),
            .bit_i (cnt_src[g]),
            .count (cnt_val[g])
        );
    end

    assign cnt_a    = cnt_val[0];
    assign cnt_prod = cnt_val[1];
    assign cnt_sum  = cnt_val[2];
endmodule

// File: rtl/sc_stream_engine_chk.sv
module sc_stream_engine_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             stream_valid,
    input logic             bit_a,
    input logic             bit_b,
    input logic             sum_bit,
    input logic [LEN_W-1:0] cnt_a,
    input logic [LEN_W-1:0] cnt_prod,
    input logic             done,
    input logic [15:0]      rng_a,
    input logic [15:0]      rng_b,
    input logic [15:0]      rng_s
);
    assert_rng_live_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rng_a != 16'h0 && rng_b != 16'h0 && rng_s != 16'h0));

    assert_seed_distinct_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rng_a != rng_b));

    assert_prod_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_prod <= cnt_a);

    assert_sum_ones_R6: assert property (@(posedge clk) disable iff (rst)
        (stream_valid && bit_a && bit_b) |-> sum_bit);

    assert_sum_zeros_R6: assert property (@(posedge clk) disable iff (rst)
        (stream_valid && !bit_a && !bit_b) |-> !sum_bit);

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        (stream_valid && $past(stream_valid)) |->
            (cnt_a == $past(cnt_a) + LEN_W'(bit_a)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_last_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (stream_valid && !busy));
endmodule

bind sc_stream_engine sc_stream_engine_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .stream_valid(stream_valid),
    .bit_a       (bit_a),
    .bit_b       (bit_b),
    .sum_bit     (sum_bit),
    .cnt_a       (cnt_a),
    .cnt_prod    (cnt_prod),
    .done        (done),
    .rng_a       (rng_a_state),
    .rng_b       (rng_b_state),
    .rng_s       (rng_s_state)
);

// File: tb/tb_sc_stream_engine.sv
module tb_sc_stream_engine;
    localparam int LEN_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [LEN_W-1:0] len_in = '0;
    logic [15:0] val_a = '0, val_b = '0, seed_a = '0, seed_b = '0, seed_s = '0;
    logic busy, stream_valid, bit_a, bit_b, bit_sel, prod_bit, sum_bit, done;
    logic [LEN_W-1:0] cnt_a, cnt_prod, cnt_sum;

    int checks = 0;
    int errors = 0;
    int valid_seen = 0;
    int done_seen = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sc_stream_engine dut (
        .clk(clk), .rst(rst), .start(start), .len_in(len_in),
        .val_a(val_a), .val_b(val_b), .seed_a(seed_a), .seed_b(seed_b), .seed_s(seed_s),
        .busy(busy), .stream_valid(stream_valid), .bit_a(bit_a), .bit_b(bit_b),
        .bit_sel(bit_sel), .prod_bit(prod_bit), .sum_bit(sum_bit),
        .cnt_a(cnt_a), .cnt_prod(cnt_prod), .cnt_sum(cnt_sum), .done(done)
    );

    // ---------------- behavioural reference ----------------
    function automatic int step16(int s);
        int fb;
        fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
        return ((s * 2) % 65536) + fb;
    endfunction

    function automatic int pick_seed(int s, int d);
        if (s == 0) return d;
        return s;
    endfunction

    task automatic eff_seeds(input int sa, input int sb, input int ss,
                             output int ea, output int eb, output int es);
        ea = pick_seed(sa, 'hACE1);
        eb = pick_seed(sb, 'h3C5B);
        es = pick_seed(ss, 'h91E7);
        if (eb == ea) eb = (ea == 65535) ? 1 : ea + 1;
    endtask

    // Model state, updated on each rising edge
    int m_ra, m_rb, m_rs, m_va, m_vb, m_len, m_idx;
    int m_ca, m_cp, m_cs;
    bit m_busy, m_valid, m_done, m_a, m_b, m_sel, m_prod, m_sum;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_valid = 0; m_done = 0;
            m_a = 0; m_b = 0; m_sel = 0; m_prod = 0; m_sum = 0;
            m_ca = 0; m_cp = 0; m_cs = 0;
        end else if (start) begin
            eff_seeds(int'(seed_a), int'(seed_b), int'(seed_s), m_ra, m_rb, m_rs);
            m_va = int'(val_a); m_vb = int'(val_b);
            m_len = (len_in == 0) ? 1024 : int'(len_in);
            m_idx = 0;
            m_busy = 1; m_valid = 0; m_done = 0;
            m_a = 0; m_b = 0; m_sel = 0; m_prod = 0; m_sum = 0;
            m_ca = 0; m_cp = 0; m_cs = 0;
        end else if (m_busy) begin
            m_a = (m_ra < m_va);
            m_b = (m_rb < m_vb);
            m_sel = (m_rs < 32768);
            m_prod = m_a && m_b;
            m_sum = m_sel ? m_a : m_b;
            m_ca += m_a; m_cp += m_prod; m_cs += m_sum;
            m_ra = step16(m_ra); m_rb = step16(m_rb); m_rs = step16(m_rs);
            m_idx++;
            m_valid = 1;
            m_done = (m_idx == m_len);
            if (m_done) m_busy = 0;
        end else begin
            m_valid = 0; m_done = 0;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (busy !== m_busy || stream_valid !== m_valid || done !== m_done ||
                bit_a !== m_a || bit_b !== m_b || bit_sel !== m_sel ||
                prod_bit !== m_prod || sum_bit !== m_sum ||
                int'(cnt_a) != m_ca || int'(cnt_prod) != m_cp || int'(cnt_sum) != m_cs) begin
                errors++;
                $display("FAIL R1/R5/R6/R7/R9 cycle compare: act busy=%0b v=%0b d=%0b a=%0b b=%0b s=%0b p=%0b u=%0b ca=%0d cp=%0d cs=%0d exp busy=%0b v=%0b d=%0b a=%0b b=%0b s=%0b p=%0b u=%0b ca=%0d cp=%0d cs=%0d",
                    busy, stream_valid, done, bit_a, bit_b, bit_sel, prod_bit, sum_bit, cnt_a, cnt_prod, cnt_sum,
                    m_busy, m_valid, m_done, m_a, m_b, m_sel, m_prod, m_sum, m_ca, m_cp, m_cs);
            end
            if (stream_valid) valid_seen++;
            if (done) done_seen++;
        end
    end

    // Independent whole-run totals
    task automatic ref_totals(input int sa, input int sb, input int ss, input int va, input int vb,
                              input int len, output int ca, output int cp, output int cs);
        int ra, rb, rs;
        bit a, b, s;
        eff_seeds(sa, sb, ss, ra, rb, rs);
        ca = 0; cp = 0; cs = 0;
        for (int i = 0; i < len; i++) begin
            a = ra < va; b = rb < vb; s = rs < 32768;
            ca += a; cp += (a && b); cs += (s ? a : b);
            ra = step16(ra); rb = step16(rb); rs = step16(rs);
        end
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic launch(input int len, input int va, input int vb,
                          input int sa, input int sb, input int ss);
        @(negedge clk);
        len_in = LEN_W'(len); val_a = 16'(va); val_b = 16'(vb);
        seed_a = 16'(sa); seed_b = 16'(sb); seed_s = 16'(ss);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        valid_seen = 0;
        done_seen = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 70000 && !done; i++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_and_check(input string tag, input int len, input int va, input int vb,
                                 input int sa, input int sb, input int ss);
        int ea, ep, es, elen;
        elen = (len == 0) ? 1024 : len;
        launch(len, va, vb, sa, sb, ss);
        wait_done();
        ref_totals(sa, sb, ss, va, vb, elen, ea, ep, es);
        check(int'(cnt_a) == ea, {tag, " R7 cnt_a"}, int'(cnt_a), ea);
        check(int'(cnt_prod) == ep, {tag, " R5 cnt_prod"}, int'(cnt_prod), ep);
        check(int'(cnt_sum) == es, {tag, " R6 cnt_sum"}, int'(cnt_sum), es);
        check(valid_seen == elen, {tag, " R8 bit count"}, valid_seen, elen);
        check(done_seen == 1, {tag, " R9 done pulses"}, done_seen, 1);
    endtask

    initial begin
        int ea, ep, es, p_eq, p_alt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(busy == 0 && stream_valid == 0 && done == 0, "R11 control idle", int'(busy), 0);
        check(cnt_a == 0 && cnt_prod == 0 && cnt_sum == 0, "R11 counters", int'(cnt_a), 0);
        check({bit_a, bit_b, bit_sel, prod_bit, sum_bit} == 5'b0, "R11 bits", int'(bit_a), 0);

        // R8 default length, mid values
        run_and_check("R8 default", 0, 'h4000, 'hC000, 'h1234, 'h4321, 'h0F0F);
        // R1 zero value gives no ones
        run_and_check("R1 zero", 300, 0, 'h9000, 'h2222, 'h3333, 'h4444);
        check(cnt_a == 0 && cnt_prod == 0, "R1 zero value count", int'(cnt_a), 0);
        // R8 boundary length 1
        run_and_check("R8 len1", 1, 'hFFFF, 'hFFFF, 'h0001, 'h0002, 'h0003);
        // R3 zero seeds take defaults
        run_and_check("R3 zero seeds", 500, 'h7000, 'h5000, 0, 0, 0);
        ref_totals('hACE1, 'h3C5B, 'h91E7, 'h7000, 'h5000, 500, ea, ep, es);
        check(int'(cnt_sum) == es && int'(cnt_prod) == ep, "R3 defaults match", int'(cnt_sum), es);
        // R4 equal seeds decorrelated
        run_and_check("R4 equal seeds", 800, 'h8000, 'h8000, 'h1234, 'h1234, 'h5555);
        p_eq = int'(cnt_prod);
        ref_totals('h1234, 'h1235, 'h5555, 'h8000, 'h8000, 800, ea, p_alt, es);
        check(p_eq == p_alt, "R4 bumped seed product", p_eq, p_alt);
        check(p_eq != int'(cnt_a), "R4 product not equal to A", p_eq, int'(cnt_a));
        // R4 bump wrap at 0xFFFF
        run_and_check("R4 wrap", 200, 'hA000, 'h6000, 'hFFFF, 'hFFFF, 'h0777);
        // R10 restart mid-run
        launch(900, 'h3000, 'h3000, 'h0101, 'h0202, 'h0303);
        repeat (100) @(negedge clk);
        run_and_check("R10 restart", 50, 'hE000, 'h2000, 'h0A0A, 'h0B0B, 'h0C0C);
        // R2 full period
        launch(65535, 'hFFFF, 'h8000, 'h0001, 'hBEEF, 'h1357);
        wait_done();
        check(int'(cnt_a) == 65534, "R2 full period ones", int'(cnt_a), 65534);
        check(valid_seen == 65535, "R2 period length", valid_seen, 65535);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule